// File: doc/BRIEF.md
# Ten-Gigabit Link Status Monitor

This block decides whether a serial ten-gigabit link is up by polling three status registers of the PHY through a Clause 45 management request interface. A pulse on `start` begins a run. Each register read goes out as two transactions to a downstream management master: an address transaction that carries the register number, then a read transaction that returns the data. From each result one status bit is taken: receive signal present, PCS block lock and lane alignment. The three bits are then combined under the loopback mode selected at `start`.

After every full round of three reads the block evaluates the link. If the link is up, the run ends with `done` and `link_up` high. If it is not up, the block checks a millisecond timeout counter. The counter advances on the `ms_tick` input and is cleared by each accepted start. If the timeout has expired, the run ends with `done` and `link_up` low. Otherwise a new round begins. The PHY port address is formed from a platform base (8 or 16, chosen by `plat_sel`) plus the port number.

States: IDLE (waits for `start`), ADDR_REQ (address transaction offered), ADDR_WAIT (waits for its response), READ_REQ (read transaction offered), READ_WAIT (waits for data; captures the bit), EVAL (judges the round), FINISH (one-cycle `done`). Transitions: IDLE→ADDR_REQ on start; ADDR_REQ→ADDR_WAIT and READ_REQ→READ_WAIT on `req_ready`; ADDR_WAIT→READ_REQ on `rsp_valid`; READ_WAIT→ADDR_REQ on `rsp_valid` for the first two sources, →EVAL after the third; EVAL→FINISH when the link is up or the timer has expired, else →ADDR_REQ; FINISH→IDLE.

Top module: `link_stat_mon`

## Requirements
- R1: While reset is held, and directly after it, `busy`, `done`, `req_valid` and `link_up` are 0.
- R2: Each register read is an address transaction (`req_op`=0, `req_data` = register number) followed by a read transaction (`req_op`=1) to the same device; the status bit comes from `rsp_data` of the read.
- R3: Every round reads device 1 register 0x000A, then device 3 register 0x0020, then device 4 register 0x0018, always in this order.
- R4: `req_prtad` equals the port number plus 8 when `plat_sel`=0, or plus 16 when `plat_sel`=1.
- R5: Only bit 0 of the device 1 result (receive signal), bit 0 of the device 3 result (block lock) and bit 12 of the device 4 result (lane alignment) affect the outcome. All other bits are ignored.
- R6: In mode 0 (`lb_mode`=0, normal) the link is up only when all three bits are set.
- R7: In modes 1 (MAC loopback) and 2 (PCS loopback) only the lane alignment bit decides.
- R8: In mode 3 (SerDes electrical wrap) alignment is ignored, and the link is up when receive signal and block lock are both set.
- R9: A run that finds the link up ends with `done` high for exactly one cycle and `link_up`=1. `link_up` holds until the next start.
- R10: If the link is not up, polling repeats. After a round completes with at least TIMEOUT_MS ticks counted, the run ends with `done` and `link_up`=0.
- R11: The tick count is cleared by each accepted start, so ticks seen while idle do not shorten a run.
- R12: An offered request holds `req_valid`, `req_op`, `req_devad` and `req_data` unchanged until `req_ready`.
- R13: A `start` pulse while a run is busy is ignored; it neither restarts the run nor clears the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| port_num | input | PORT_W | PHY port number |
| plat_sel | input | 1 | Port base select: 0 = base 8, 1 = base 16 |
| lb_mode | input | 2 | 0 normal, 1 MAC loopback, 2 PCS loopback, 3 SerDes wrap |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| link_up | output | 1 | Result of the last run |
| req_valid | output | 1 | Management request offered |
| req_ready | input | 1 | Management master accepts request |
| req_op | output | 1 | 0 address transaction, 1 read transaction |
| req_prtad | output | 5 | Port address |
| req_devad | output | 5 | Device address |
| req_data | output | 16 | Register number for address transactions |
| rsp_valid | input | 1 | Response strobe |
| rsp_data | input | 16 | Read data |

## Verification
The bench builds the block with TIMEOUT_MS=4 and drives a tick every 100 cycles. This lets a failing run reach the timeout within a few hundred cycles, so every combination of mode and status bits can be run to completion, including runs that must fail. It also reaches the cases where the link comes up mid-run, where a second start arrives during a run, and where many ticks pass while the block is idle. The management responder inserts random ready and response delays and fills the unused result bits with random values.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR_REQ, ST_ADDR_WAIT, ST_READ_REQ, ST_READ_WAIT, ST_EVAL, ST_FINISH
    } lsm_state_e;

    typedef enum logic [1:0] {
        LB_NONE = 2'd0, LB_MAC = 2'd1, LB_PCS = 2'd2, LB_EWRAP = 2'd3
    } lsm_lb_e;

    localparam int NSRC = 3;

    // Source 0: receive signal, 1: block lock, 2: lane alignment
    function automatic logic [4:0] src_devad(input logic [1:0] i);
        unique case (i)
            2'd0:    return 5'd1;
            2'd1:    return 5'd3;
            default: return 5'd4;
        endcase
    endfunction

    function automatic logic [15:0] src_reg(input logic [1:0] i);
        unique case (i)
            2'd0:    return 16'h000A;
            2'd1:    return 16'h0020;
            default: return 16'h0018;
        endcase
    endfunction

    function automatic logic [3:0] src_bit(input logic [1:0] i);
        unique case (i)
            2'd0:    return 4'd0;
            2'd1:    return 4'd0;
            default: return 4'd12;
        endcase
    endfunction
endpackage

// File: rtl/lsm_timer.sv
module lsm_timer #(
    parameter int TIMEOUT_MS = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic ms_tick,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_MS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_MS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && ms_tick && (cnt < LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt >= LIMIT);
endmodule

// File: rtl/lsm_judge.sv
module lsm_judge
    import lsm_pkg::*;
(
    input  lsm_lb_e    mode,
    input  logic [2:0] bits,
    output logic       link_ok
);
    logic sig, lock, align;
    assign sig   = bits[0];
    assign lock  = bits[1];
    assign align = bits[2];

    always_comb begin
        unique case (mode)
            LB_NONE:         link_ok = sig && lock && align;
            LB_MAC, LB_PCS:  link_ok = align;
            LB_EWRAP:        link_ok = sig && lock;
            default:         link_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [4:0]  prtad_in,
    input  lsm_lb_e     mode_in,
    input  logic        link_ok,
    input  logic        expired,
    output lsm_lb_e     mode_q,
    output logic [2:0]  bits_q,
    output logic        run_clear,
    output logic        busy,
    output logic        done,
    output logic        link_up,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_op,
    output logic [4:0]  req_prtad,
    output logic [4:0]  req_devad,
    output logic [15:0] req_data,
    input  logic        rsp_valid,
    input  logic [15:0] rsp_data
);
    lsm_state_e state, nxt;
    logic [1:0] idx;
    logic [4:0] prt_q;
    logic       result;
    logic       last_src;

    assign last_src  = (idx == 2'(NSRC - 1));
    assign run_clear = (state == ST_IDLE) && start;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (start)     nxt = ST_ADDR_REQ;
            ST_ADDR_REQ:  if (req_ready) nxt = ST_ADDR_WAIT;
            ST_ADDR_WAIT: if (rsp_valid) nxt = ST_READ_REQ;
            ST_READ_REQ:  if (req_ready) nxt = ST_READ_WAIT;
            ST_READ_WAIT: if (rsp_valid) nxt = last_src ? ST_EVAL : ST_ADDR_REQ;
            ST_EVAL:      nxt = (link_ok || expired) ? ST_FINISH : ST_ADDR_REQ;
            ST_FINISH:    nxt = ST_IDLE;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            bits_q <= '0;
            prt_q  <= '0;
            mode_q <= LB_NONE;
            result <= 1'b0;
        end else begin
            state <= nxt;
            if (run_clear) begin
                idx    <= '0;
                bits_q <= '0;
                prt_q  <= prtad_in;
                mode_q <= mode_in;
                result <= 1'b0;
            end
            if (state == ST_READ_WAIT && rsp_valid) begin
                bits_q[idx] <= rsp_data[src_bit(idx)];
                idx         <= last_src ? 2'd0 : idx + 2'd1;
            end
            if (state == ST_EVAL) begin
                result <= link_ok;
            end
        end
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_FINISH);
        link_up   = result;
        req_valid = (state == ST_ADDR_REQ) || (state == ST_READ_REQ);
        req_op    = (state == ST_READ_REQ);
        req_prtad = prt_q;
        req_devad = src_devad(idx);
        req_data  = (state == ST_ADDR_REQ) ? src_reg(idx) : 16'h0000;
    end
endmodule

// File: rtl/link_stat_mon.sv
module link_stat_mon
    import lsm_pkg::*;
#(
    parameter int PORT_W     = 3,
    parameter int TIMEOUT_MS = 3000,
    parameter int BASE_LO    = 8,
    parameter int BASE_HI    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PORT_W-1:0] port_num,
    input  logic              plat_sel,
    input  logic [1:0]        lb_mode,
    input  logic              ms_tick,
    output logic              busy,
    output logic              done,
    output logic              link_up,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_op,
    output logic [4:0]        req_prtad,
    output logic [4:0]        req_devad,
    output logic [15:0]       req_data,
    input  logic              rsp_valid,
    input  logic [15:0]       rsp_data
);
    logic [4:0] prt_base;
    logic [4:0] prtad_calc;
    lsm_lb_e    mode_q;
    logic [2:0] bits_q;
    logic       link_ok;
    logic       tmr_expired;
    logic       run_clear;

    assign prt_base   = plat_sel ? 5'(BASE_HI) : 5'(BASE_LO);
    assign prtad_calc = prt_base + 5'(port_num);

    lsm_seq u_seq (
        .clk, .rst_n, .start,
        .prtad_in (prtad_calc),
        .mode_in  (lsm_lb_e'(lb_mode)),
        .link_ok, .expired(tmr_expired),
        .mode_q, .bits_q, .run_clear,
        .busy, .done, .link_up,
        .req_valid, .req_ready, .req_op, .req_prtad, .req_devad, .req_data,
        .rsp_valid, .rsp_data
    );

    lsm_judge u_judge (
        .mode    (mode_q),
        .bits    (bits_q),
        .link_ok (link_ok)
    );

    lsm_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
        .clk, .rst_n,
        .clear   (run_clear),
        .run     (busy),
        .ms_tick,
        .expired (tmr_expired)
    );
endmodule

// File: rtl/lsm_chk.sv
module lsm_chk #(
    parameter int PORT_W  = 3,
    parameter int BASE_LO = 8,
    parameter int BASE_HI = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              link_up,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_op,
    input logic [4:0]        req_prtad,
    input logic [4:0]        req_devad,
    input logic [15:0]       req_data,
    input logic [PORT_W-1:0] port_num,
    input logic              plat_sel,
    input logic              tmr_expired
);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_op)
            && $stable(req_devad) && $stable(req_data));

    p_devad_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_devad == 5'd1 || req_devad == 5'd3 || req_devad == 5'd4));

    // Port and platform inputs are held steady by the environment during a run
    p_prtad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_prtad == 5'(port_num)
            + (plat_sel ? 5'(BASE_HI) : 5'(BASE_LO)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_fail_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && !link_up |-> tmr_expired);

    p_req_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);
endmodule

bind link_stat_mon lsm_chk #(.PORT_W(PORT_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) chk_i (
    .clk, .rst_n, .busy, .done, .link_up, .req_valid, .req_ready, .req_op,
    .req_prtad, .req_devad, .req_data, .port_num, .plat_sel,
    .tmr_expired(tmr_expired)
);

// File: tb/link_stat_mon_tb_top.sv
module link_stat_mon_tb_top;
    localparam int PORT_W = 3;
    localparam int TMO    = 4;
    localparam int TICK_P = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [PORT_W-1:0] port_num = '0;
    logic plat_sel = 1'b0;
    logic [1:0] lb_mode = '0;
    logic ms_tick = 1'b0;
    logic busy, done, link_up, req_valid, req_op;
    logic req_ready = 1'b0;
    logic [4:0] req_prtad, req_devad;
    logic [15:0] req_data;
    logic rsp_valid = 1'b0;
    logic [15:0] rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int tick_total = 0;
    logic [2:0] stat_bits = '0;   // bench register model: sig, lock, align
    int sl_idx = 0;
    int sl_phase = 0;

    always #5 clk = ~clk;

    link_stat_mon #(.PORT_W(PORT_W), .TIMEOUT_MS(TMO)) dut_i (
        .clk, .rst_n, .start, .port_num, .plat_sel, .lb_mode, .ms_tick,
        .busy, .done, .link_up, .req_valid, .req_ready, .req_op,
        .req_prtad, .req_devad, .req_data, .rsp_valid, .rsp_data
    );

    always @(posedge clk) if (ms_tick) tick_total <= tick_total + 1;

    function automatic bit exp_up(input logic [1:0] m, input logic [2:0] b);
        case (m)
            2'd0:    return b[0] && b[1] && b[2];
            2'd1,
            2'd2:    return b[2];
            default: return b[0] && b[1];
        endcase
    endfunction

    function automatic logic [4:0] exp_dev(input int i);
        return (i == 0) ? 5'd1 : (i == 1) ? 5'd3 : 5'd4;
    endfunction

    function automatic logic [15:0] exp_reg(input int i);
        return (i == 0) ? 16'h000A : (i == 1) ? 16'h0020 : 16'h0018;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic slave_loop();
        forever begin
            @(negedge clk);
            if (req_valid) begin
                logic op;
                logic [4:0] dv, pa;
                logic [15:0] dt, val;
                int bp;
                repeat ($urandom_range(0, 2)) @(negedge clk);
                op = req_op; dv = req_devad; pa = req_prtad; dt = req_data;
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                chk("R2 op order", 32'(op), 32'(sl_phase));
                chk("R3 devad", 32'(dv), 32'(exp_dev(sl_idx)));
                chk("R4 prtad", 32'(pa),
                    32'(5'(port_num) + (plat_sel ? 5'd16 : 5'd8)));
                if (!op) chk("R3 register", 32'(dt), 32'(exp_reg(sl_idx)));
                repeat ($urandom_range(0, 3)) @(negedge clk);
                val = 16'($urandom);
                bp = (sl_idx == 2) ? 12 : 0;
                val[bp] = stat_bits[sl_idx];
                rsp_data = op ? val : 16'($urandom);
                rsp_valid = 1'b1;
                if (op) sl_idx = (sl_idx + 1) % 3;
                sl_phase = op ? 0 : 1;
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    endtask

    task automatic tick_gen();
        forever begin
            repeat (TICK_P - 1) @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
        end
    endtask

    // Run one poll; restart_at > 0 pulses start again after that many ticks
    task automatic run_poll(input logic [1:0] m, input logic [2:0] b,
                            input int up_after, input int restart_at,
                            input string tag);
        int t0, n;
        bit e, restarted;
        lb_mode = m; stat_bits = b; sl_idx = 0; sl_phase = 0;
        port_num = PORT_W'($urandom); plat_sel = 1'($urandom);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = tick_total;
        restarted = 0;
        e = exp_up(m, b);
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
            if (up_after > 0 && tick_total - t0 >= up_after) begin
                stat_bits = 3'b111; e = 1'b1;
            end
            if (restart_at > 0 && !restarted && tick_total - t0 >= restart_at && !done) begin
                start = 1'b1; restarted = 1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        chk({tag, " done seen"}, 32'(done), 32'd1);
        chk({tag, " link_up"}, 32'(link_up), 32'(e));
        if (!e) begin
            chk("R10 ticks >= timeout", 32'(tick_total - t0 >= TMO), 32'd1);
            chk("R11 R13 ticks bounded", 32'(tick_total - t0 <= TMO + 2), 32'd1);
        end
        @(negedge clk);
        chk("R9 done one cycle", 32'({done, busy}), 32'd0);
        chk("R9 link_up held", 32'(link_up), 32'(e));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fork
            slave_loop();
            tick_gen();
        join_none
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 32'({busy, done, req_valid, link_up}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 32'({busy, done, req_valid, link_up}), 32'd0);

        // Directed: every mode against every bit combination
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 8; b++) begin
                run_poll(2'(m), 3'(b), 0, 0,
                         (m == 0) ? "R6 R5" : (m == 3) ? "R8 R5" : "R7 R5");
            end
        end
        // Random patterns
        for (int k = 0; k < 12; k++) begin
            run_poll(2'($urandom), 3'($urandom), 0, 0, "R5 R6 R7 R8 random");
        end
        // Link comes up partway through polling
        run_poll(2'd0, 3'b000, 2, 0, "R10 late up");
        // Second start while busy must not restart the timer
        run_poll(2'd0, 3'b011, 0, 3, "R13 restart ignored");
        // Idle ticks must not count toward the next run
        repeat (TICK_P * 6) @(negedge clk);
        run_poll(2'd3, 3'b001, 0, 0, "R11 idle ticks");
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule